// File: doc/BRIEF.md
# Double-Precision Compare with Condition Flags

This block compares two IEEE-754 binary64 operands and turns the outcome into a 4-bit condition code that marks less-than, greater-than, equal or unordered. On every enabled compare the code goes to one of eight condition fields, picked by a 3-bit index, and it also replaces a 4-bit result-flags register. Both are written in every case, unordered results included. The block then reports the invalid-operation causes that apply. Which causes those are depends on the compare flavour (ordered or unordered) and on whether a NaN operand is signalling or quiet.

Operations enter on a valid/ready stream and leave on a registered valid/ready result stream. An operation is accepted on a rising clock edge where `in_valid` and `in_ready` are both high. `in_ready` is high whenever the result slot is empty or the consumer is taking the current result that same cycle. While `out_valid` is high and `out_ready` is low, the result is held unchanged and no new operation is accepted. The condition fields and the flags are updated on the same edge that loads the result. When `fpu_en` is low, an accepted operation produces only an FPU-unavailable result and touches no state.

Top module: `fp64_cmp_flags`

## Requirements
- R1: The result code uses bit 3 for A<B (1000), bit 2 for A>B (0100), bit 1 for A==B (0010) and bit 0 for unordered (0001). Exactly one bit is set for every enabled compare.
- R2: A NaN has an all-ones exponent (bits 62:52) and a non-zero fraction. If either operand is a NaN, the code is 0001 whatever the other operand is. Infinities are ordered values, so +inf is above every finite value and -inf is below every finite value.
- R3: +0 and -0 compare equal. Any negative operand is below any positive one. Two negative operands order by inverted magnitude.
- R4: An enabled compare writes the code into condition field k, where k is `in_crf`. Field k sits at `cr_fields[31-4k:28-4k]`. The other seven fields keep their values.
- R5: An enabled compare replaces `fp_flags` with the new code, and this includes unordered results.
- R6: Unordered flavour (`in_ordered`=0): `out_vxsnan` is 1 exactly when an operand is a signalling NaN, meaning fraction bit 51 is 0. `out_vxvc` is always 0.
- R7: Ordered flavour (`in_ordered`=1): a signalling NaN operand raises `out_vxsnan` only. A quiet NaN with no signalling NaN raises `out_vxvc` only. Non-NaN operands raise neither.
- R8: With `fpu_en`=0, an accepted operation gives `out_fpu_unavail`=1, code 0000 and no invalid-operation flags, and it leaves `cr_fields` and `fp_flags` unchanged.
- R9: `in_ready` = !out_valid || out_ready. The result appears one edge after acceptance. It is held stable while `out_valid` && !`out_ready`, and `out_valid` drops after a transfer that has no new acceptance.
- R10: After reset, `out_valid`, `cr_fields` and `fp_flags` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| fpu_en | input | 1 | Floating-point unit enabled |
| in_valid | input | 1 | Operation offered |
| in_ready | output | 1 | Operation can be accepted |
| in_opa | input | 64 | Operand A, binary64 |
| in_opb | input | 64 | Operand B, binary64 |
| in_crf | input | 3 | Destination condition field index |
| in_ordered | input | 1 | 1 = ordered flavour, 0 = unordered flavour |
| out_valid | output | 1 | Result available |
| out_ready | input | 1 | Consumer takes the result |
| out_code | output | 4 | Condition code of the result |
| out_crf | output | 3 | Field index the result was written to |
| out_vxsnan | output | 1 | Invalid operation: signalling NaN operand |
| out_vxvc | output | 1 | Invalid operation: ordered compare on quiet NaN |
| out_fpu_unavail | output | 1 | Operation refused, unit disabled |
| cr_fields | output | 32 | Eight 4-bit condition fields, field 0 most significant |
| fp_flags | output | 4 | Result-flags field of the status register |

## Verification
A wrong internal state is visible at the ports within one clock edge, because the result register, the condition fields and the flags are all loaded on the acceptance edge. A faulty classifier or magnitude chain shows up first as a wrong code or a wrong exception bit on the result. A misdirected field write corrupts a neighbouring nibble of `cr_fields`, and this is seen at the next sample. A broken hold path changes the result while it is stalled, and the per-cycle comparison catches that in the first stalled cycle.

// File: rtl/fcmp_pkg.sv
package fcmp_pkg;
  localparam int unsigned FP_W   = 64;
  localparam int unsigned EXP_W  = 11;
  localparam int unsigned FRAC_W = 52;
  localparam int unsigned CODE_W = 4;

  localparam logic [CODE_W-1:0] CC_LT   = 4'b1000;
  localparam logic [CODE_W-1:0] CC_GT   = 4'b0100;
  localparam logic [CODE_W-1:0] CC_EQ   = 4'b0010;
  localparam logic [CODE_W-1:0] CC_UN   = 4'b0001;
  localparam logic [CODE_W-1:0] CC_NONE = 4'b0000;

  typedef struct packed {
    logic is_nan;
    logic is_snan;
  } opclass_t;

  typedef struct packed {
    logic [CODE_W-1:0] code;
    logic              vx_snan;
    logic              vx_cmp;
    logic              unavail;
  } verdict_t;
endpackage

// File: rtl/fp64_classify.sv
module fp64_classify import fcmp_pkg::*; (
  input  logic [FP_W-1:0] op_i,
  output opclass_t        cls_o
);
  logic [EXP_W-1:0]  exp_f;
  logic [FRAC_W-1:0] frac_f;
  logic              exp_max;
  logic              frac_nz;

  assign exp_f   = op_i[FP_W-2 -: EXP_W];
  assign frac_f  = op_i[FRAC_W-1:0];
  assign exp_max = &exp_f;
  assign frac_nz = |frac_f;

  // quiet bit is the top fraction bit; cleared means signalling
  assign cls_o.is_nan  = exp_max & frac_nz;
  assign cls_o.is_snan = exp_max & frac_nz & ~frac_f[FRAC_W-1];
endmodule

// File: rtl/fp64_order.sv
module fp64_order import fcmp_pkg::*; #(
  parameter int unsigned CHUNK_W = 8
) (
  input  logic [FP_W-1:0] a_i,
  input  logic [FP_W-1:0] b_i,
  output logic            lt_o,
  output logic            le_o
);
  localparam int unsigned MAG_W   = FP_W - 1;
  localparam int unsigned N_CHUNK = (MAG_W + CHUNK_W - 1) / CHUNK_W;
  localparam int unsigned PAD_W   = N_CHUNK * CHUNK_W;

  logic [PAD_W-1:0]   mag_a, mag_b;
  logic [N_CHUNK-1:0] c_gt, c_eq;
  logic [N_CHUNK:0]   gt_chain, eq_chain;
  logic               mag_gt, mag_eq, mag_lt;
  logic               sa, sb, both_zero;

  assign mag_a = PAD_W'(a_i[MAG_W-1:0]);
  assign mag_b = PAD_W'(b_i[MAG_W-1:0]);
  assign sa    = a_i[FP_W-1];
  assign sb    = b_i[FP_W-1];

  // per-chunk magnitude compare, resolved from the most significant chunk down
  assign gt_chain[N_CHUNK] = 1'b0;
  assign eq_chain[N_CHUNK] = 1'b1;
  for (genvar g = 0; g < N_CHUNK; g++) begin : g_chunk
    assign c_gt[g]     = mag_a[g*CHUNK_W +: CHUNK_W] > mag_b[g*CHUNK_W +: CHUNK_W];
    assign c_eq[g]     = mag_a[g*CHUNK_W +: CHUNK_W] == mag_b[g*CHUNK_W +: CHUNK_W];
    assign gt_chain[g] = gt_chain[g+1] | (eq_chain[g+1] & c_gt[g]);
    assign eq_chain[g] = eq_chain[g+1] & c_eq[g];
  end

  assign mag_gt    = gt_chain[0];
  assign mag_eq    = eq_chain[0];
  assign mag_lt    = ~mag_gt & ~mag_eq;
  assign both_zero = ~|mag_a & ~|mag_b;

  logic eq_w;
  always_comb begin
    lt_o = 1'b0;
    eq_w = 1'b0;
    if (both_zero) begin
      eq_w = 1'b1;
    end else if (sa != sb) begin
      lt_o = sa;
    end else if (!sa) begin
      lt_o = mag_lt;
      eq_w = mag_eq;
    end else begin
      lt_o = mag_gt;
      eq_w = mag_eq;
    end
    le_o = lt_o | eq_w;
  end
endmodule

// File: rtl/cmp_cr_bank.sv
module cmp_cr_bank #(
  parameter  int unsigned N_FIELDS = 8,
  parameter  int unsigned FIELD_W  = 4,
  localparam int unsigned IDX_W    = (N_FIELDS > 1) ? $clog2(N_FIELDS) : 1
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          wr_en,
  input  logic [IDX_W-1:0]              wr_idx,
  input  logic [FIELD_W-1:0]            wr_val,
  output logic [N_FIELDS*FIELD_W-1:0]   fields_o
);
  // field k lives in slot N_FIELDS-1-k so field 0 is most significant
  for (genvar k = 0; k < N_FIELDS; k++) begin : g_field
    localparam int unsigned SLOT = N_FIELDS - 1 - k;
    logic hit;
    assign hit = wr_en && (wr_idx == IDX_W'(k));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   fields_o[SLOT*FIELD_W +: FIELD_W] <= '0;
      else if (hit) fields_o[SLOT*FIELD_W +: FIELD_W] <= wr_val;
    end

    p_field_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_idx == IDX_W'(k)) |=> fields_o[SLOT*FIELD_W +: FIELD_W] == $past(wr_val));
    p_field_keep_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_en && wr_idx == IDX_W'(k)) |=> $stable(fields_o[SLOT*FIELD_W +: FIELD_W]));
  end
endmodule

// File: rtl/fp64_cmp_flags.sv
module fp64_cmp_flags import fcmp_pkg::*; #(
  parameter  int unsigned N_CRF   = 8,
  parameter  int unsigned CHUNK_W = 8,
  localparam int unsigned IDX_W   = (N_CRF > 1) ? $clog2(N_CRF) : 1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      fpu_en,
  input  logic                      in_valid,
  output logic                      in_ready,
  input  logic [FP_W-1:0]           in_opa,
  input  logic [FP_W-1:0]           in_opb,
  input  logic [IDX_W-1:0]          in_crf,
  input  logic                      in_ordered,
  output logic                      out_valid,
  input  logic                      out_ready,
  output logic [CODE_W-1:0]         out_code,
  output logic [IDX_W-1:0]          out_crf,
  output logic                      out_vxsnan,
  output logic                      out_vxvc,
  output logic                      out_fpu_unavail,
  output logic [N_CRF*CODE_W-1:0]   cr_fields,
  output logic [CODE_W-1:0]         fp_flags
);
  localparam int unsigned N_OPS = 2;

  logic             accept;
  logic [FP_W-1:0]  ops [N_OPS];
  opclass_t         cls [N_OPS];
  logic             a_lt, a_le;
  logic             any_nan, any_snan;
  verdict_t         vd;

  assign in_ready = ~out_valid | out_ready;
  assign accept   = in_valid & in_ready;

  assign ops[0] = in_opa;
  assign ops[1] = in_opb;

  for (genvar i = 0; i < N_OPS; i++) begin : g_cls
    fp64_classify u_cls (.op_i(ops[i]), .cls_o(cls[i]));
  end

  fp64_order #(.CHUNK_W(CHUNK_W)) u_order (
    .a_i (in_opa),
    .b_i (in_opb),
    .lt_o(a_lt),
    .le_o(a_le)
  );

  assign any_nan  = cls[0].is_nan  | cls[1].is_nan;
  assign any_snan = cls[0].is_snan | cls[1].is_snan;

  // NaN check first; magnitude result is used only for ordered operands
  always_comb begin
    vd = '0;
    if (!fpu_en) begin
      vd.unavail = 1'b1;
      vd.code    = CC_NONE;
    end else begin
      if (any_nan)    vd.code = CC_UN;
      else if (a_lt)  vd.code = CC_LT;
      else if (!a_le) vd.code = CC_GT;
      else            vd.code = CC_EQ;
      vd.vx_snan = any_nan & any_snan;
      vd.vx_cmp  = in_ordered & any_nan & ~any_snan;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid       <= 1'b0;
      out_code        <= CC_NONE;
      out_crf         <= '0;
      out_vxsnan      <= 1'b0;
      out_vxvc        <= 1'b0;
      out_fpu_unavail <= 1'b0;
    end else if (accept) begin
      out_valid       <= 1'b1;
      out_code        <= vd.code;
      out_crf         <= in_crf;
      out_vxsnan      <= vd.vx_snan;
      out_vxvc        <= vd.vx_cmp;
      out_fpu_unavail <= vd.unavail;
    end else if (out_ready) begin
      out_valid       <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                fp_flags <= '0;
    else if (accept && fpu_en) fp_flags <= vd.code;
  end

  cmp_cr_bank #(.N_FIELDS(N_CRF), .FIELD_W(CODE_W)) u_bank (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (accept & fpu_en),
    .wr_idx  (in_crf),
    .wr_val  (vd.code),
    .fields_o(cr_fields)
  );

  p_code_onehot_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_fpu_unavail) |-> $countones(out_code) == 1);
  p_flags_follow_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && fpu_en) |=> fp_flags == out_code);
  p_exc_unord_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && (out_vxsnan || out_vxvc)) |-> out_code == CC_UN);
  p_exc_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !(out_vxsnan && out_vxvc));
  p_unavail_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_fpu_unavail) |-> (out_code == CC_NONE && !out_vxsnan && !out_vxvc));
  p_no_update_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !fpu_en) |=> ($stable(fp_flags) && $stable(cr_fields)));
  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_code) && $stable(out_crf)
      && $stable({out_vxsnan, out_vxvc, out_fpu_unavail})));
endmodule

// File: tb/fp64_cmp_flags_tb_top.sv
`timescale 1ns/1ps
module fp64_cmp_flags_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        fpu_en = 1'b1;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [63:0] in_opa = '0, in_opb = '0;
  logic [2:0]  in_crf = '0;
  logic        in_ordered = 1'b0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [3:0]  out_code;
  logic [2:0]  out_crf;
  logic        out_vxsnan, out_vxvc, out_fpu_unavail;
  logic [31:0] cr_fields;
  logic [3:0]  fp_flags;

  always #2.5 clk = ~clk;

  fp64_cmp_flags dut_i (
    .clk(clk), .rst_n(rst_n), .fpu_en(fpu_en),
    .in_valid(in_valid), .in_ready(in_ready),
    .in_opa(in_opa), .in_opb(in_opb), .in_crf(in_crf), .in_ordered(in_ordered),
    .out_valid(out_valid), .out_ready(out_ready), .out_code(out_code), .out_crf(out_crf),
    .out_vxsnan(out_vxsnan), .out_vxvc(out_vxvc), .out_fpu_unavail(out_fpu_unavail),
    .cr_fields(cr_fields), .fp_flags(fp_flags)
  );

  localparam logic [63:0] K_ONE  = 64'h3FF0000000000000, K_TWO  = 64'h4000000000000000;
  localparam logic [63:0] K_NONE = 64'hBFF0000000000000, K_NTWO = 64'hC000000000000000;
  localparam logic [63:0] K_PZ   = 64'h0000000000000000, K_NZ   = 64'h8000000000000000;
  localparam logic [63:0] K_PINF = 64'h7FF0000000000000, K_NINF = 64'hFFF0000000000000;
  localparam logic [63:0] K_QNAN = 64'h7FF8000000000000, K_SNAN = 64'h7FF0000000000001;
  localparam logic [63:0] K_NQN  = 64'hFFF8000000000005, K_NSN  = 64'hFFF4000000000000;
  localparam logic [63:0] K_TINY = 64'h0000000000000001, K_MAX  = 64'h7FEFFFFFFFFFFFFF;

  int n_checks = 0, n_fail = 0;
  bit done = 0;

  // reference model state (value after the most recent edge)
  bit          m_valid = 0;
  logic [3:0]  m_code = '0;
  logic [2:0]  m_crf = '0;
  bit          m_vxs = 0, m_vxc = 0, m_unav = 0;
  logic [31:0] m_cr = '0;
  logic [3:0]  m_flags = '0;
  string       m_tag = "R1";

  function automatic bit f_nan(logic [63:0] x);
    return (&x[62:52]) && (|x[51:0]);
  endfunction
  function automatic bit f_snan(logic [63:0] x);
    return f_nan(x) && !x[51];
  endfunction
  function automatic logic [3:0] f_code(logic [63:0] a, logic [63:0] b);
    real ra, rb;
    if (f_nan(a) || f_nan(b)) return 4'b0001;
    ra = $bitstoreal(a);
    rb = $bitstoreal(b);
    if (ra < rb) return 4'b1000;
    if (ra > rb) return 4'b0100;
    return 4'b0010;
  endfunction

  task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic compare_all();
    chk("R9", "out_valid", 64'(out_valid), 64'(m_valid));
    if (m_valid) begin
      chk(m_tag, "out_code", 64'(out_code), 64'(m_code));
      chk("R4", "out_crf", 64'(out_crf), 64'(m_crf));
      chk("R6", "out_vxsnan", 64'(out_vxsnan), 64'(m_vxs));
      chk("R7", "out_vxvc", 64'(out_vxvc), 64'(m_vxc));
      chk("R8", "out_fpu_unavail", 64'(out_fpu_unavail), 64'(m_unav));
    end
    chk("R4", "cr_fields", 64'(cr_fields), 64'(m_cr));
    chk("R5", "fp_flags", 64'(fp_flags), 64'(m_flags));
  endtask

  // called just after a falling edge; covers one full cycle
  task automatic step(bit v, logic [63:0] a, logic [63:0] b, logic [2:0] f,
                      bit ord, bit en, bit rdy);
    bit rdy_exp;
    in_valid = v; in_opa = a; in_opb = b; in_crf = f;
    in_ordered = ord; fpu_en = en; out_ready = rdy;
    #1;
    rdy_exp = !m_valid || rdy;
    chk("R9", "in_ready", 64'(in_ready), 64'(rdy_exp));
    if (v && rdy_exp) begin
      m_valid = 1; m_crf = f;
      if (!en) begin
        m_code = 4'b0000; m_vxs = 0; m_vxc = 0; m_unav = 1; m_tag = "R8";
      end else begin
        m_code = f_code(a, b); m_unav = 0;
        m_vxs  = f_snan(a) || f_snan(b);
        m_vxc  = ord && (f_nan(a) || f_nan(b)) && !m_vxs;
        if (f_nan(a) || f_nan(b) || (&a[62:52]) || (&b[62:52])) m_tag = "R2";
        else if (a[63] || b[63] || a[62:0] == 0 || b[62:0] == 0) m_tag = "R3";
        else m_tag = "R1";
        m_cr[31-4*f -: 4] = m_code;
        m_flags = m_code;
      end
    end else if (rdy) begin
      m_valid = 0;
    end
    @(negedge clk);
    compare_all();
  endtask

  function automatic logic [63:0] pick(int sel);
    case (sel)
      0: return K_ONE;   1: return K_TWO;   2: return K_NONE;  3: return K_NTWO;
      4: return K_PZ;    5: return K_NZ;    6: return K_PINF;  7: return K_NINF;
      8: return K_QNAN;  9: return K_SNAN;  10: return K_NQN;  11: return K_NSN;
      12: return K_TINY; 13: return K_MAX;
      default: return {$urandom(), $urandom()};
    endcase
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    // R10: reset state
    chk("R10", "out_valid", 64'(out_valid), 64'd0);
    chk("R10", "cr_fields", 64'(cr_fields), 64'd0);
    chk("R10", "fp_flags", 64'(fp_flags), 64'd0);
    chk("R9", "in_ready", 64'(in_ready), 64'd1);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 ordinary orderings into distinct fields
    step(1, K_ONE, K_TWO, 3'd0, 0, 1, 1);
    step(1, K_TWO, K_ONE, 3'd1, 1, 1, 1);
    step(1, K_ONE, K_ONE, 3'd2, 0, 1, 1);
    step(1, K_TINY, K_MAX, 3'd7, 1, 1, 1);
    // R3 signed zeros and negatives
    step(1, K_PZ, K_NZ, 3'd3, 0, 1, 1);
    step(1, K_NZ, K_PZ, 3'd4, 1, 1, 1);
    step(1, K_NTWO, K_NONE, 3'd5, 0, 1, 1);
    step(1, K_NONE, K_NTWO, 3'd6, 1, 1, 1);
    step(1, K_NONE, K_ONE, 3'd0, 0, 1, 1);
    // R2 infinities and NaNs; R6 / R7 exception flavours
    step(1, K_PINF, K_MAX, 3'd1, 0, 1, 1);
    step(1, K_NINF, K_NTWO, 3'd2, 1, 1, 1);
    step(1, K_QNAN, K_ONE, 3'd3, 0, 1, 1);
    step(1, K_ONE, K_SNAN, 3'd4, 0, 1, 1);
    step(1, K_QNAN, K_NQN, 3'd5, 1, 1, 1);
    step(1, K_SNAN, K_QNAN, 3'd6, 1, 1, 1);
    step(1, K_PINF, K_NSN, 3'd7, 1, 1, 1);
    step(1, K_QNAN, K_QNAN, 3'd0, 1, 1, 1);
    // R8 unit disabled: no state change
    step(1, K_ONE, K_TWO, 3'd1, 0, 0, 1);
    step(1, K_SNAN, K_ONE, 3'd2, 1, 0, 1);
    step(0, K_ONE, K_ONE, 3'd0, 0, 1, 1);
    // R9 back-pressure: result held, offers refused
    step(1, K_TWO, K_ONE, 3'd3, 0, 1, 0);
    step(1, K_ONE, K_TWO, 3'd4, 0, 1, 0);
    step(1, K_ONE, K_TWO, 3'd4, 0, 1, 0);
    step(1, K_ONE, K_TWO, 3'd4, 0, 1, 1);
    step(0, K_ONE, K_TWO, 3'd4, 0, 1, 1);
    // random mix of specials and arbitrary encodings
    for (int n = 0; n < 4000; n++) begin
      step(($urandom() % 4) != 0, pick($urandom() % 18), pick($urandom() % 18),
           3'($urandom()), 1'($urandom()), ($urandom() % 8) != 0, ($urandom() % 4) != 0);
    end
    done = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule